// File: doc/BRIEF.md
# Character LCD Nibble Transmitter

This block moves 8-bit command and data bytes to a character display module over a 4-bit bus. Each byte goes out as two nibbles, high nibble first. Two mode lines travel with every nibble and tell the display what the byte means. A read/write line and an enable strobe complete the bus. Before every byte the block reads the display's status nibble until its busy bit reads clear.

Out of reset the block runs a fixed start-up program of six command bytes and accepts no host traffic meanwhile. After that, the mode lines rest at the data encoding. Each host byte arrives with its own 2-bit mode, which drives the mode lines only while that byte is in flight. A clear-display request is therefore a command-mode byte 0x01, after which the lines fall back to data mode.

Top module: `lcd_nib_tx`

## Requirements
- R1: While reset is held, the enable and read/write lines are low, the data bus is driven (output enable high), and ready is low.
- R2: The mode lines carry the mode of the byte in flight: 00 command, 01 display address, 10 data, 11 cursor address. They stay unchanged across both nibbles and every enable pulse of that byte.
- R3: A written byte appears as two enable pulses with read/write low. The first carries bits 7:4 and the second carries bits 3:0 on the data lines.
- R4: Before each byte at least one status read occurs. Only bit 3 of the read nibble is the busy flag, and the other bits are ignored. Reads repeat while it is 1, and no write pulse occurs until a read returns it as 0.
- R5: For a status read, read/write goes high and the bus output enable goes low before enable rises. Both stay there until after enable falls, and then the bus is driven again.
- R6: Enable stays high for exactly EN_CYC clock cycles per pulse. Data, mode and read/write are held for SETUP_CYC cycles before it rises and after it falls.
- R7: After reset the bytes 0xDB, 0x50, 0x3B, 0x0D, 0x05, 0x01 are sent in that order in command mode, and ready stays low until the last has been sent.
- R8: After start-up and after each host byte, the mode lines return to 10 (data) whenever the block is idle.
- R9: A request is taken when valid and ready are both high in the same cycle. Ready is low from the next cycle until that byte has been sent, and exactly one byte goes out per acceptance.
- R10: A request of byte 0x01 with mode 00 sends a clear command in command mode, after which the idle mode lines read 10 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Block can take a request |
| req_byte_i | input | 8 | Byte to send |
| req_mode_i | input | 2 | Mode for the byte ({OC2,OC1} encoding) |
| lcd_data_o | output | 4 | Nibble driven onto the display bus |
| lcd_data_oe_o | output | 1 | Bus output enable (0 during status reads) |
| lcd_data_i | input | 4 | Nibble read back from the display bus |
| lcd_mode_o | output | 2 | Mode lines {OC2,OC1} |
| lcd_rw_o | output | 1 | Read/write line, 1 = read |
| lcd_en_o | output | 1 | Enable strobe |

## Verification
The assertions take for granted that the display eventually reports not-busy. Otherwise the block waits forever and no idle-state property is ever reached. They also assume request fields only matter in the cycle of acceptance. The bench's display model returns busy for a random 0 to 3 reads after each byte and fills the unused status bits with a fixed nonzero pattern. It raises valid only at a falling clock edge, with fields stable, and drops it right after acceptance. Random bytes and all four modes are mixed with directed cases for the start-up list and the clear command.

// File: rtl/lcd_nib_pkg.sv
package lcd_nib_pkg;
  localparam int INIT_LEN = 6;

  typedef enum logic [1:0] {
    MODE_CMD   = 2'b00,
    MODE_DADDR = 2'b01,
    MODE_DATA  = 2'b10,
    MODE_CADDR = 2'b11
  } lcd_mode_e;

  function automatic logic [7:0] init_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'hDB;
      3'd1:    return 8'h50;
      3'd2:    return 8'h3B;
      3'd3:    return 8'h0D;
      3'd4:    return 8'h05;
      default: return 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/lcd_init_rom.sv
module lcd_init_rom #(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  assign byte_o = lcd_nib_pkg::init_byte(3'(idx_i));
endmodule

// File: rtl/lcd_nib_phy.sv
module lcd_nib_phy #(
  parameter int SETUP_CYC = 2,
  parameter int EN_CYC    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic [3:0] nib_i,
  output logic       done_o,
  output logic [3:0] rd_nib_o,
  output logic [3:0] lcd_data_o,
  output logic       lcd_data_oe_o,
  input  logic [3:0] lcd_data_i,
  output logic       lcd_rw_o,
  output logic       lcd_en_o
);
  localparam int MAXC = (SETUP_CYC > EN_CYC) ? SETUP_CYC : EN_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_HIGH, P_HOLD} ph_e;

  ph_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          op_q, done_q;
  logic [3:0]    nib_q, rdn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= P_IDLE; cnt_q <= '0; op_q <= 1'b0;
      done_q <= 1'b0; nib_q <= '0; rdn_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        P_IDLE: if (start_i) begin
          op_q <= rd_i; nib_q <= nib_i;
          st_q <= P_SETUP; cnt_q <= CW'(SETUP_CYC - 1);
        end
        P_SETUP: if (cnt_q == '0) begin
          st_q <= P_HIGH; cnt_q <= CW'(EN_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        P_HIGH: if (cnt_q == '0) begin
          rdn_q <= lcd_data_i;
          st_q <= P_HOLD; cnt_q <= CW'(SETUP_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == '0) begin
          st_q <= P_IDLE; done_q <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign lcd_en_o      = (st_q == P_HIGH);
  assign lcd_rw_o      = op_q && (st_q != P_IDLE);
  assign lcd_data_oe_o = !lcd_rw_o;
  assign lcd_data_o    = nib_q;
  assign done_o        = done_q;
  assign rd_nib_o      = rdn_q;

  // independent pulse-width monitor
  logic [CW:0] en_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_run_q <= '0;
    else if (lcd_en_o) en_run_q <= en_run_q + 1'b1;
    else en_run_q <= '0;
  end

  AST_EN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_en_o) |-> en_run_q == (CW+1)'(EN_CYC)); // R6
  AST_EN_HOLD_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_en_o |-> $stable(lcd_rw_o) && $stable(lcd_data_o) && $stable(lcd_data_oe_o)); // R6
  AST_RD_THROUGH_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_en_o) |-> $stable(lcd_rw_o) && $stable(lcd_data_oe_o)); // R5
endmodule

// File: rtl/lcd_nib_tx.sv
module lcd_nib_tx #(
  parameter int SETUP_CYC = 2,
  parameter int EN_CYC    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic [7:0] req_byte_i,
  input  logic [1:0] req_mode_i,
  output logic [3:0] lcd_data_o,
  output logic       lcd_data_oe_o,
  input  logic [3:0] lcd_data_i,
  output logic [1:0] lcd_mode_o,
  output logic       lcd_rw_o,
  output logic       lcd_en_o
);
  import lcd_nib_pkg::*;

  localparam int IDX_W = $clog2(INIT_LEN);

  typedef enum logic [1:0] {T_IDLE, T_POLL, T_HI, T_LO} tx_e;

  tx_e              st_q;
  logic [7:0]       byte_q, init_b;
  logic [1:0]       mode_q;
  logic [IDX_W-1:0] idx_q;
  logic             init_done_q, start_q;
  logic             phy_done;
  logic [3:0]       rd_nib, phy_nib;

  lcd_init_rom #(.IDX_W(IDX_W)) u_rom (.idx_i(idx_q), .byte_o(init_b));

  assign phy_nib = (st_q == T_HI) ? byte_q[7:4] : byte_q[3:0];

  lcd_nib_phy #(.SETUP_CYC(SETUP_CYC), .EN_CYC(EN_CYC)) u_phy (
    .clk_i, .rst_ni,
    .start_i(start_q), .rd_i(st_q == T_POLL), .nib_i(phy_nib),
    .done_o(phy_done), .rd_nib_o(rd_nib),
    .lcd_data_o, .lcd_data_oe_o, .lcd_data_i, .lcd_rw_o, .lcd_en_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= T_IDLE; byte_q <= '0; mode_q <= MODE_CMD;
      idx_q <= '0; init_done_q <= 1'b0; start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        T_IDLE: if (!init_done_q) begin
          byte_q <= init_b; mode_q <= MODE_CMD;
          st_q <= T_POLL; start_q <= 1'b1;
        end else if (req_valid_i) begin
          byte_q <= req_byte_i; mode_q <= req_mode_i;
          st_q <= T_POLL; start_q <= 1'b1;
        end
        T_POLL: if (phy_done) begin
          start_q <= 1'b1;
          if (!rd_nib[3]) st_q <= T_HI;   // busy flag on bit 3
        end
        T_HI: if (phy_done) begin
          st_q <= T_LO; start_q <= 1'b1;
        end
        default: if (phy_done) begin
          st_q <= T_IDLE;
          if (init_done_q) mode_q <= MODE_DATA;
          else if (idx_q == IDX_W'(INIT_LEN - 1)) begin
            init_done_q <= 1'b1; mode_q <= MODE_DATA;
          end else idx_q <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign req_ready_o = (st_q == T_IDLE) && init_done_q;
  assign lcd_mode_o  = mode_q;

  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !lcd_en_o && !lcd_rw_o && lcd_data_oe_o); // R9
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i |=> !req_ready_o); // R9
  AST_IDLE_DATA_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> lcd_mode_o == MODE_DATA); // R8
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_en_o |-> $stable(lcd_mode_o)); // R2
endmodule

// File: tb/lcd_nib_tx_tb.sv
module lcd_nib_tx_tb;
  localparam int SETUP_CYC = 2;
  localparam int EN_CYC    = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid = 1'b0, req_ready;
  logic [7:0] req_byte = '0;
  logic [1:0] req_mode = '0;
  logic [3:0] lcd_dout, lcd_din;
  logic       lcd_oe, lcd_rw, lcd_en;
  logic [1:0] lcd_mode;

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int busy_left = 2, exp_polls = 3, polls = 0;
  int en_width = 0;
  logic en_prev = 1'b0, half = 1'b0, finished = 1'b0;
  logic [3:0] hi_nib;
  logic [1:0] hi_mode;
  logic [7:0] got_b[$], exp_b[$];
  logic [1:0] got_m[$], exp_m[$];

  // low bits are noise; only bit 3 means busy (R4)
  assign lcd_din = {busy_left > 0, 3'b101};

  lcd_nib_tx #(.SETUP_CYC(SETUP_CYC), .EN_CYC(EN_CYC)) u_dut (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_byte_i(req_byte), .req_mode_i(req_mode),
    .lcd_data_o(lcd_dout), .lcd_data_oe_o(lcd_oe), .lcd_data_i(lcd_din),
    .lcd_mode_o(lcd_mode), .lcd_rw_o(lcd_rw), .lcd_en_o(lcd_en)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // display model
  always @(negedge clk) begin
    if (rst_ni) begin
      if (en_prev && !lcd_en) begin
        chk(en_width == EN_CYC, "R6 enable width", en_width, EN_CYC);
        if (lcd_rw) begin
          chk(!lcd_oe, "R5 bus released on read", lcd_oe, 0);
          polls++;
          if (busy_left > 0) busy_left--;
        end else if (!half) begin
          chk(busy_left == 0, "R4 write while busy", busy_left, 0);
          hi_nib = lcd_dout; hi_mode = lcd_mode; half = 1'b1;
        end else begin
          chk(lcd_mode == hi_mode, "R2 mode across nibbles", lcd_mode, hi_mode);
          chk(polls == exp_polls, "R4 poll count", polls, exp_polls);
          got_b.push_back({hi_nib, lcd_dout});
          got_m.push_back(lcd_mode);
          half = 1'b0; polls = 0;
          busy_left = int'($urandom_range(3));
          exp_polls = busy_left + 1;
        end
      end
      en_width = lcd_en ? en_width + 1 : 0;
      en_prev  = lcd_en;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      finish_run();
    end
  end

  task automatic wait_bytes(input int n);
    while (got_b.size() < n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic [1:0] m, input string tag);
    int n;
    n = exp_b.size();
    @(negedge clk);
    req_valid = 1'b1; req_byte = b; req_mode = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_byte = ~b;
    chk(!req_ready, "R9 ready low after accept", req_ready, 0);
    exp_b.push_back(b); exp_m.push_back(m);
    wait_bytes(n + 1);
    chk(got_b[n] == b, {tag, " byte"}, got_b[n], b);
    chk(got_m[n] == m, {tag, " mode"}, got_m[n], m);
    while (!req_ready) @(negedge clk);
    chk(got_b.size() == n + 1, "R9 one byte per accept", got_b.size(), n + 1);
    chk(lcd_mode == 2'b10, "R8 idle data mode", lcd_mode, 2'b10);
  endtask

  initial begin
    logic [7:0] init_exp [6];
    void'($urandom(32'h1cd5));
    init_exp = '{8'hDB, 8'h50, 8'h3B, 8'h0D, 8'h05, 8'h01};
    repeat (3) @(negedge clk);
    chk(!lcd_en && !lcd_rw && lcd_oe && !req_ready, "R1 reset state",
        {lcd_en, lcd_rw, lcd_oe, req_ready}, 4'b0010);
    rst_ni = 1'b1;
    while (!req_ready) @(negedge clk);
    chk(got_b.size() == 6, "R7 ready after start-up list", got_b.size(), 6);
    for (int i = 0; i < 6; i++) begin
      exp_b.push_back(init_exp[i]); exp_m.push_back(2'b00);
      chk(got_b[i] == init_exp[i], "R7 start-up byte", got_b[i], init_exp[i]);
      chk(got_m[i] == 2'b00, "R7 start-up mode", got_m[i], 0);
    end
    chk(lcd_mode == 2'b10, "R8 data mode after start-up", lcd_mode, 2'b10);
    // directed modes and nibble order
    send(8'hA5, 2'b01, "R2 R3 display address");
    send(8'h3C, 2'b11, "R2 R3 cursor address");
    send(8'hF0, 2'b10, "R3 data");
    send(8'h0F, 2'b00, "R3 command");
    send(8'h01, 2'b00, "R10 clear");
    chk(lcd_mode == 2'b10, "R10 mode back to data", lcd_mode, 2'b10);
    // random traffic with gaps
    for (int k = 0; k < 40; k++) begin
      repeat ($urandom_range(3)) @(negedge clk);
      send(8'($urandom), 2'($urandom), "R2 R3 random");
    end
    finish_run();
  end
endmodule